// File: doc/BRIEF.md
# Programmable Address Sequencer with Hardware Loops

This block feeds addresses to one local data memory. It runs a small program held in a 64-word instruction store. Each instruction either sets up the address datapath (base, stride, circular length, bit-reverse width), produces one address, opens a hardware loop, or halts. The unit does no work on its own. It executes one instruction only in a cycle where the consumer raises `req`, so with `req` low nothing is fetched or decoded. A `start` pulse begins a run at word 0, and a halt instruction ends it by raising `done`.

Address patterns are post-increment, pre-increment, circular (modulo) wrap within a window above the base, and bit-reversed indexing over a power-of-two span of up to 64 points. A loop controller keeps up to four nested loop levels. Taking a loop-back costs no request cycle, and several levels may close on the same instruction. A loop instruction that cannot be honoured sets a sticky error flag and is skipped.

Top module: `ag_seq_top`

## Requirements
- R1: After reset `addr_valid`, `done` and `err` are low, and the unit stays halted: `req` produces no address until `start` is pulsed.
- R2: Program words are written through `prog_we`/`prog_waddr`/`prog_wdata`. A `start` pulse clears every datapath register, the loop nest, `done` and `err`, and the next executing cycle runs word 0. An instruction executes only at a clock edge where the unit is running and `req` is high. In any other cycle `addr_valid` is low one cycle later and no state changes.
- R3: Opcode 5 (bits 31:28) post-increment: the address is base+pointer, then pointer = wrap(pointer+stride). The address appears on `addr_out` with `addr_valid` high in the cycle after the request edge.
- R4: Opcode 6 pre-increment: pointer = wrap(pointer+stride) first, and the address is base plus the new pointer.
- R5: Opcode 3 loads a circular length L from bits 15:0. With L nonzero, wrap(s) is s−L when s ≥ L, so the address stays in [base, base+L) for strides below L. With L zero the pointer wraps modulo 2^16.
- R6: Opcode 4 loads a bit-reverse width k from bits 2:0, with values above 6 clamped to 6. Opcode 7 issues base plus the low k bits of an internal counter, bit-reversed, then increments that counter modulo 2^k.
- R7: Opcode 8 opens a loop over words pc+1 through the end field (bits 21:16), repeated by the count in bits 15:0. Returning from the end word to the body start takes no extra request cycle.
- R8: Up to four loops nest. When several levels end on one word, exhausted inner levels close and the innermost level with iterations left branches.
- R9: A loop instruction with four levels already open, with end ≤ pc, with a body longer than eight words, or with count 0 sets `err` (sticky until `start`) and is otherwise ignored.
- R10: Opcode 0 halts: one cycle later `done` is high. From then on `req` has no effect until `start`, which clears `done`.
- R11: Opcode 1 loads the base from bits 15:0 and clears the pointer and the bit-reverse counter. Opcode 2 loads the stride. Setup opcodes 1–4, the loop opcode and unused opcodes 9–15 issue no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program store write enable |
| prog_waddr | input | PCW | Program store write address |
| prog_wdata | input | 32 | Program word to write |
| start | input | 1 | Begin a run at word 0 |
| req | input | 1 | Request strobe: execute one instruction |
| addr_out | output | AW | Generated address |
| addr_valid | output | 1 | `addr_out` holds a new address |
| done | output | 1 | Halt instruction reached |
| err | output | 1 | Sticky rejected-loop flag |

## Verification
The checker watches properties that hold on every cycle. The outputs are quiet after reset and after `start`. No address appears unless a request was made. A halted unit ignores requests. The error flag only clears on `start`. The loop depth never exceeds four. The exact address sequences for each addressing mode, the loop-back order with shared end words, and which malformed loop instructions are rejected can only be shown by the bench's programs. The bench runs these programs against its own instruction-level model, under random request gaps.

// File: rtl/ag_pkg.sv
package ag_pkg;
  localparam int IW      = 32;
  localparam int OPC_LSB = 28;
  localparam int END_LSB = 16;
  localparam int IMM_W   = 16;

  typedef enum logic [3:0] {
    OP_HALT      = 4'd0,
    OP_SETBASE   = 4'd1,
    OP_SETSTRIDE = 4'd2,
    OP_SETMOD    = 4'd3,
    OP_SETBR     = 4'd4,
    OP_POST      = 4'd5,
    OP_PRE       = 4'd6,
    OP_BREV      = 4'd7,
    OP_LOOP      = 4'd8
  } ag_op_e;
endpackage

// File: rtl/ag_progmem.sv
module ag_progmem #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  parameter int AWD   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AWD-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic           re,
  input  logic [AWD-1:0] raddr,
  output logic [W-1:0]   rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read with enable: only fetches when asked
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ag_loopctl.sv
module ag_loopctl #(
  parameter int LEVELS  = 4,
  parameter int MAXBODY = 8,
  parameter int PCW     = 6,
  parameter int CW      = 16,
  parameter int DW      = $clog2(LEVELS+1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           step,
  input  logic           is_loop,
  input  logic [PCW-1:0] pc,
  input  logic [PCW-1:0] loop_end,
  input  logic [CW-1:0]  loop_cnt,
  output logic [PCW-1:0] next_pc,
  output logic           loop_bad,
  output logic [DW-1:0]  depth
);
  localparam int IXW = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  logic [PCW-1:0] st_q [LEVELS];
  logic [PCW-1:0] en_q [LEVELS];
  logic [CW-1:0]  cn_q [LEVELS];
  logic [DW-1:0]  depth_q, new_depth;
  logic [PCW-1:0] pc_inc, body;
  logic           take, alive;
  logic [IXW-1:0] take_idx;

  assign depth = depth_q;

  always_comb begin
    pc_inc    = pc + 1'b1;
    body      = loop_end - pc;
    loop_bad  = is_loop && ((depth_q == DW'(LEVELS)) || (loop_end <= pc) ||
                            (body > PCW'(MAXBODY)) || (loop_cnt == '0));
    next_pc   = pc_inc;
    new_depth = depth_q;
    take      = 1'b0;
    take_idx  = '0;
    alive     = 1'b1;
    if (!is_loop) begin
      // walk from the innermost open level outward
      for (int i = LEVELS-1; i >= 0; i--) begin
        if (alive && (i < int'(depth_q))) begin
          if (pc == en_q[i]) begin
            if (cn_q[i] > CW'(1)) begin
              next_pc   = st_q[i];
              take      = 1'b1;
              take_idx  = IXW'(i);
              new_depth = DW'(i + 1);
              alive     = 1'b0;
            end else begin
              new_depth = DW'(i);
            end
          end else begin
            alive = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      depth_q <= '0;
    end else if (step) begin
      if (is_loop) begin
        if (!loop_bad) depth_q <= depth_q + 1'b1;
      end else begin
        depth_q <= new_depth;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (step && !clear) begin
      if (is_loop && !loop_bad) begin
        st_q[depth_q[IXW-1:0]] <= pc_inc;
        en_q[depth_q[IXW-1:0]] <= loop_end;
        cn_q[depth_q[IXW-1:0]] <= loop_cnt;
      end else if (take) begin
        cn_q[take_idx] <= cn_q[take_idx] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ag_addrpath.sv
module ag_addrpath import ag_pkg::*; #(
  parameter int AW    = 16,
  parameter int BRMAX = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [3:0]       op,
  input  logic [IMM_W-1:0] imm,
  output logic [AW-1:0]    addr_out,
  output logic             addr_valid
);
  localparam int BLW = $clog2(BRMAX+1);

  logic [AW-1:0]    base_q, ptr_q, stride_q, len_q;
  logic [BLW-1:0]   blog_q, imm_blog;
  logic [BRMAX-1:0] bcnt_q, rev, bmask;
  logic [AW-1:0]    s_raw, s_wrap;

  always_comb begin
    s_raw  = ptr_q + stride_q;
    s_wrap = ((len_q != '0) && (s_raw >= len_q)) ? (s_raw - len_q) : s_raw;
    rev    = '0;
    bmask  = '0;
    for (int i = 0; i < BRMAX; i++) begin
      if (i < int'(blog_q)) begin
        rev[i]   = bcnt_q[int'(blog_q) - 1 - i];
        bmask[i] = 1'b1;
      end
    end
    imm_blog = (int'(imm[BLW-1:0]) > BRMAX) ? BLW'(BRMAX) : imm[BLW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      base_q <= '0; ptr_q <= '0; stride_q <= '0; len_q <= '0;
      blog_q <= '0; bcnt_q <= '0;
      addr_out <= '0; addr_valid <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      if (step) begin
        case (op)
          OP_SETBASE: begin
            base_q <= AW'(imm); ptr_q <= '0; bcnt_q <= '0;
          end
          OP_SETSTRIDE: stride_q <= AW'(imm);
          OP_SETMOD:    len_q    <= AW'(imm);
          OP_SETBR:     blog_q   <= imm_blog;
          OP_POST: begin
            addr_out   <= base_q + ptr_q;
            ptr_q      <= s_wrap;
            addr_valid <= 1'b1;
          end
          OP_PRE: begin
            addr_out   <= base_q + s_wrap;
            ptr_q      <= s_wrap;
            addr_valid <= 1'b1;
          end
          OP_BREV: begin
            addr_out   <= base_q + AW'(rev);
            bcnt_q     <= (bcnt_q + 1'b1) & bmask;
            addr_valid <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ag_seq_top.sv
module ag_seq_top import ag_pkg::*; #(
  parameter int AW         = 16,
  parameter int PROG_DEPTH = 64,
  parameter int LEVELS     = 4,
  parameter int MAXBODY    = 8,
  parameter int BRMAX      = 6,
  parameter int PCW        = $clog2(PROG_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           prog_we,
  input  logic [PCW-1:0] prog_waddr,
  input  logic [31:0]    prog_wdata,
  input  logic           start,
  input  logic           req,
  output logic [AW-1:0]  addr_out,
  output logic           addr_valid,
  output logic           done,
  output logic           err
);
  localparam int DW = $clog2(LEVELS+1);

  logic           run_q, done_q, err_q;
  logic [PCW-1:0] pc_q, next_pc, fetch_addr;
  logic [IW-1:0]  ir;
  logic [3:0]     op;
  logic           step, is_halt, is_loop, fetch_en, loop_bad;
  logic [DW-1:0]  loop_depth;

  assign op         = ir[OPC_LSB +: 4];
  assign step       = run_q & req & ~start;
  assign is_halt    = (op == OP_HALT);
  assign is_loop    = (op == OP_LOOP);
  assign fetch_en   = start | (step & ~is_halt);
  assign fetch_addr = start ? '0 : next_pc;

  ag_progmem #(.DEPTH(PROG_DEPTH), .W(IW), .AWD(PCW)) u_mem (
    .clk(clk), .we(prog_we), .waddr(prog_waddr), .wdata(prog_wdata),
    .re(fetch_en), .raddr(fetch_addr), .rdata(ir)
  );

  ag_loopctl #(.LEVELS(LEVELS), .MAXBODY(MAXBODY), .PCW(PCW), .CW(IMM_W), .DW(DW)) u_loop (
    .clk(clk), .rst(rst), .clear(start), .step(step), .is_loop(is_loop),
    .pc(pc_q), .loop_end(PCW'(ir[END_LSB +: 6])), .loop_cnt(ir[IMM_W-1:0]),
    .next_pc(next_pc), .loop_bad(loop_bad), .depth(loop_depth)
  );

  ag_addrpath #(.AW(AW), .BRMAX(BRMAX)) u_ap (
    .clk(clk), .rst(rst), .clear(start), .step(step), .op(op),
    .imm(ir[IMM_W-1:0]), .addr_out(addr_out), .addr_valid(addr_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; pc_q <= '0;
    end else if (start) begin
      run_q <= 1'b1; done_q <= 1'b0; err_q <= 1'b0; pc_q <= '0;
    end else if (step) begin
      pc_q  <= next_pc;
      err_q <= err_q | loop_bad;
      if (is_halt) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/ag_seq_chk.sv
module ag_seq_chk #(
  parameter int LEVELS = 4,
  parameter int DW     = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          req,
  input logic          addr_valid,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] depth
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!addr_valid && !done && !err));

  a_r2_no_req_no_addr: assert property (@(posedge clk) disable iff (rst)
    !$past(req) |-> !addr_valid);

  a_r10_halted_ignores_req: assert property (@(posedge clk) disable iff (rst)
    ($past(done) && !$past(start)) |-> !addr_valid);

  a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> (!done && !err && !addr_valid && depth == '0));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(err) && !$past(start)) |-> err);

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
    int'(depth) <= LEVELS);
endmodule

bind ag_seq_top ag_seq_chk #(.LEVELS(LEVELS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .req(req), .addr_valid(addr_valid),
  .done(done), .err(err), .depth(loop_depth)
);

// File: tb/tb_ag_seq_top.sv
module tb_ag_seq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_waddr = '0;
  logic [31:0] prog_wdata = '0;
  logic        start = 1'b0;
  logic        req = 1'b0;
  logic [15:0] addr_out;
  logic        addr_valid, done, err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ag_seq_top dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_waddr(prog_waddr),
    .prog_wdata(prog_wdata), .start(start), .req(req), .addr_out(addr_out),
    .addr_valid(addr_valid), .done(done), .err(err)
  );

  // ---------------- bench model ----------------
  logic [31:0] mprog [64];
  int mpc, mrun, base, ptr, stride, mlen, blog, bcnt, mdepth;
  int ls [4], le [4], lc [4];
  bit ev, edone, eerr;
  int eaddr;
  string etag;

  function automatic logic [31:0] ins(int op, int en, int imm);
    return {4'(op), 6'd0, 6'(en), 16'(imm)};
  endfunction

  function automatic int wrapv(int p);
    int s = (p + stride) & 32'hFFFF;
    if (mlen != 0 && s >= mlen) s = s - mlen;
    return s;
  endfunction

  task automatic m_reset();
    mpc = 0; mrun = 1; base = 0; ptr = 0; stride = 0; mlen = 0;
    blog = 0; bcnt = 0; mdepth = 0; edone = 0; eerr = 0;
  endtask

  task automatic m_exec();
    logic [31:0] w = mprog[mpc];
    int op = int'(w[31:28]);
    int imm = int'(w[15:0]);
    int en = int'(w[21:16]);
    int nxt = (mpc + 1) % 64;
    int r;
    etag = "R11";
    case (op)
      0: begin mrun = 0; edone = 1; etag = "R10"; end
      1: begin base = imm; ptr = 0; bcnt = 0; end
      2: stride = imm;
      3: mlen = imm;
      4: blog = (imm & 7) > 6 ? 6 : (imm & 7);
      5: begin ev = 1; eaddr = (base + ptr) & 32'hFFFF; ptr = wrapv(ptr);
               etag = (mlen != 0) ? "R5" : "R3"; end
      6: begin ev = 1; ptr = wrapv(ptr); eaddr = (base + ptr) & 32'hFFFF;
               etag = (mlen != 0) ? "R5" : "R4"; end
      7: begin
        r = 0;
        for (int i = 0; i < blog; i++) r |= ((bcnt >> (blog - 1 - i)) & 1) << i;
        ev = 1; eaddr = (base + r) & 32'hFFFF;
        bcnt = (bcnt + 1) & ((1 << blog) - 1);
        etag = "R6";
      end
      8: begin
        etag = "R7";
        if (mdepth == 4 || en <= mpc || en - mpc > 8 || imm == 0) begin
          eerr = 1; etag = "R9";
        end else begin
          ls[mdepth] = mpc + 1; le[mdepth] = en; lc[mdepth] = imm; mdepth++;
        end
      end
      default: ;
    endcase
    if (op != 8) begin
      while (mdepth > 0 && mpc == le[mdepth-1]) begin
        if (lc[mdepth-1] > 1) begin
          lc[mdepth-1]--; nxt = ls[mdepth-1]; break;
        end
        mdepth--;
      end
    end
    mpc = nxt;
  endtask

  // ---------------- checking ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(string ptag);
    chk(addr_valid == ev, {ptag, "/", etag, " valid"}, addr_valid, ev);
    if (ev) chk(addr_out == 16'(eaddr), {ptag, "/", etag, " addr"}, addr_out, eaddr);
    chk(done == edone, {ptag, "/R10 done"}, done, edone);
    chk(err == eerr, {ptag, "/R9 err"}, err, eerr);
  endtask

  task automatic tick(bit r, string ptag);
    req = r;
    ev = 0; etag = "R2";
    if (mrun != 0 && r) m_exec();
    @(posedge clk); @(negedge clk);
    compare(ptag);
  endtask

  task automatic load(int n);
    for (int i = 0; i < n; i++) begin
      prog_we = 1; prog_waddr = 6'(i); prog_wdata = mprog[i];
      @(posedge clk); @(negedge clk);
    end
    prog_we = 0;
  endtask

  task automatic run_prog(int n, string ptag, bit dense);
    load(n);
    req = 0; start = 1;
    @(posedge clk); @(negedge clk);
    start = 0;
    m_reset();
    ev = 0; etag = "R2";
    compare(ptag);
    for (int c = 0; c < 600 && mrun != 0; c++)
      tick(dense ? 1'b1 : ($urandom % 4 != 0), ptag);
    for (int c = 0; c < 3; c++) tick(1'b1, ptag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mprog[i] = '0;
    mrun = 0; edone = 0; eerr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state and requests before start are ignored
    chk(!addr_valid && !done && !err, "R1 reset outputs", {addr_valid, done, err}, 0);
    for (int c = 0; c < 4; c++) tick(1'b1, "R1");

    // post / pre increment, no wrap (R3, R4)
    mprog[0] = ins(1, 0, 16'h0100); mprog[1] = ins(2, 0, 3);
    for (int i = 2; i < 6; i++) mprog[i] = ins(5, 0, 0);
    mprog[6] = ins(6, 0, 0); mprog[7] = ins(6, 0, 0); mprog[8] = ins(12, 0, 0);
    mprog[9] = ins(0, 0, 0);
    run_prog(10, "R3", 0);

    // circular window (R5)
    mprog[0] = ins(1, 0, 16'h0200); mprog[1] = ins(3, 0, 5); mprog[2] = ins(2, 0, 2);
    for (int i = 3; i < 10; i++) mprog[i] = ins(5, 0, 0);
    for (int i = 10; i < 13; i++) mprog[i] = ins(6, 0, 0);
    mprog[13] = ins(0, 0, 0);
    run_prog(14, "R5", 0);

    // bit reverse, including clamp of width 7 to 6 (R6)
    mprog[0] = ins(1, 0, 16'h0040); mprog[1] = ins(4, 0, 3);
    for (int i = 2; i < 11; i++) mprog[i] = ins(7, 0, 0);
    mprog[11] = ins(4, 0, 7); mprog[12] = ins(1, 0, 16'h1000);
    for (int i = 13; i < 17; i++) mprog[i] = ins(7, 0, 0);
    mprog[17] = ins(0, 0, 0);
    run_prog(18, "R6", 0);

    // loops with a shared end word (R7, R8), back-to-back requests
    mprog[0] = ins(1, 0, 0); mprog[1] = ins(2, 0, 1);
    mprog[2] = ins(8, 5, 3); mprog[3] = ins(5, 0, 0);
    mprog[4] = ins(8, 5, 2); mprog[5] = ins(6, 0, 0); mprog[6] = ins(0, 0, 0);
    run_prog(7, "R7", 1);

    // four distinct nested levels (R8)
    mprog[0] = ins(2, 0, 1); mprog[1] = ins(8, 8, 2); mprog[2] = ins(8, 7, 2);
    mprog[3] = ins(8, 6, 2); mprog[4] = ins(8, 5, 3); mprog[5] = ins(5, 0, 0);
    mprog[6] = ins(6, 0, 0); mprog[7] = ins(5, 0, 0); mprog[8] = ins(7, 0, 0);
    mprog[9] = ins(0, 0, 0);
    run_prog(10, "R8", 0);

    // rejected loops (R9): long body, zero count, end<=pc, fifth level
    mprog[0] = ins(8, 10, 2); mprog[1] = ins(5, 0, 0); mprog[2] = ins(8, 2, 1);
    mprog[3] = ins(8, 9, 0);
    for (int i = 4; i < 9; i++) mprog[i] = ins(8, 12, 2);
    mprog[9] = ins(2, 0, 1); mprog[10] = ins(5, 0, 0); mprog[11] = ins(6, 0, 0);
    mprog[12] = ins(7, 0, 0); mprog[13] = ins(0, 0, 0);
    run_prog(14, "R9", 0);

    // random straight-line programs (R3 R4 R5 R6 R11)
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 30; i++) begin
        int op = 1 + $urandom % 14;
        int imm = (op == 3) ? ($urandom % 40) : (op == 2 ? $urandom % 50 : $urandom % 65536);
        if (op == 8) op = 5;
        mprog[i] = ins(op, 0, imm);
      end
      mprog[30] = ins(0, 0, 0);
      run_prog(31, "R11", 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule